// File: doc/BRIEF.md
# Tagged Receive FIFO with Character Timeout

This block sits behind a serial receiver and queues each received character with the three error flags that came with it: parity, framing and break. Every entry keeps its own flags. The entry at the head of the queue is shown on a registered holding-register output. Its flags appear on line-status bits 2 to 4. A host read removes the head, and the next entry and its flags show on the following clock.

The block raises a receive interrupt in one of two ways. In per-character mode it fires whenever any data is waiting. In threshold mode it waits until the fill level reaches a programmable trigger level. A character timeout makes sure a partial batch below the threshold still reaches the host. The timeout fires after a quiet period of four character lengths plus twelve bit times. Both are measured in 16x sample ticks, and the character length comes from a 2-bit word-length setting. An enable input gates the interrupt.

Top module: `rxq_top`

## Requirements
- R1: Characters leave the queue in arrival order, and up to DEPTH (default 128) characters can be held at once.
- R2: The head character appears on `rhr_data` at the first clock edge after it is written into an empty queue. After a host read, the next character appears at the clock edge that accepts the read.
- R3: The error flags of the head character appear on `lsr_flags`: bit 2 is parity, bit 3 is framing and bit 4 is break. They change together with `rhr_data`, and all three are 0 while the queue is empty.
- R4: `lsr_flags[0]` (data ready) is 1 exactly when the queue holds at least one character. Every output is 0 after reset.
- R5: A character that arrives while the queue is full, and that is not accompanied by a host read, is dropped. It also sets `lsr_flags[1]` (overrun), which stays set until the next host read.
- R6: A host read while the queue is empty has no effect on the queue.
- R7: When `trig_en` is 0 and `rx_ien` is 1, `rx_irq` goes high one clock after data ready goes high.
- R8: When `trig_en` is 1, the fill-level condition for `rx_irq` holds only while the fill level is at or above `trig_lvl`. `rx_irq` follows that condition with one clock of latency.
- R9: While `rx_ien` is 0, `rx_irq` is 0 from the next clock on.
- R10: `rx_tmo` rises once L ticks of `tick16` have passed with the queue non-empty and no write or read, where L = 16 × (4 × (5 + `wlen_sel`) + 12). While `rx_ien` is 1, `rx_tmo` also raises `rx_irq` one clock later.
- R11: Every accepted write and every accepted host read clears `rx_tmo` and restarts the quiet-period count.
- R12: `rx_tmo` is never high while the queue is empty, and the count does not run while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| tick16 | input | 1 | 16x sample-clock enable |
| host_rd | input | 1 | Host reads and removes the head character |
| wlen_sel | input | 2 | Word length: 0=5, 1=6, 2=7, 3=8 data bits |
| rx_ien | input | 1 | Receive interrupt enable |
| trig_en | input | 1 | 1 = threshold mode, 0 = per-character mode |
| trig_lvl | input | CNT_W (8) | Fill-level threshold |
| rhr_data | output | 8 | Head character |
| lsr_flags | output | 5 | Bit 0 ready, bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break |
| rx_irq | output | 1 | Receive interrupt |
| rx_tmo | output | 1 | Character timeout status |

## Verification
A read pointer that slips skips, repeats or reorders characters. So does a head register that misses the bypass path. Both show on `rhr_data` at the first read after the slip, and the per-entry flags expose a wrong entry even when two data bytes match. A fill count that drifts shows up within one clock, either as data ready staying high after the last read or as an early or late overrun when the queue is filled. A timeout counter that restarts on the wrong event, or uses the wrong word-length limit, moves the rising edge of `rx_tmo` away from the exact tick the bench predicts, so the error shows at that edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  rxq_entry_t    wr_word,
  input  logic          rd_en,
  output rxq_entry_t    head,
  output logic [CW-1:0] level,
  output logic          ready,
  output logic          overrun,
  output logic          push_ok,
  output logic          pop_ok
);
  rxq_entry_t    mem [DEPTH];
  rxq_entry_t    head_q;
  logic [AW-1:0] wr_ptr, rd_ptr, rd_nxt;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          full_c, empty_c, ready_q, ovr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_c  = (lvl_q == CW'(DEPTH));
  assign empty_c = (lvl_q == '0);
  assign pop_ok  = rd_en && !empty_c;
  assign push_ok = wr_en && (!full_c || pop_ok);
  assign rd_nxt  = pop_ok ? bump(rd_ptr) : rd_ptr;

  always_comb begin
    lvl_d = lvl_q;
    if (push_ok && !pop_ok) lvl_d = lvl_q + 1'b1;
    else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
  end

  // storage array: write port only, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_word;
  end

  // look-ahead read: head register always holds the entry at the next read pointer
  always_ff @(posedge clk) begin
    if (rst) head_q <= '0;
    else if (push_ok && (wr_ptr == rd_nxt)) head_q <= wr_word;
    else head_q <= mem[rd_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      lvl_q   <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      rd_ptr  <= rd_nxt;
      lvl_q   <= lvl_d;
      ready_q <= (lvl_d != '0);
      if (wr_en && full_c && !pop_ok) ovr_q <= 1'b1;
      else if (rd_en) ovr_q <= 1'b0;
    end
  end

  assign head    = head_q;
  assign level   = lvl_q;
  assign ready   = ready_q;
  assign overrun = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= CW'(DEPTH)); // R1
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty_c && !wr_en) |=> (lvl_q == '0)); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full_c && !rd_en) |=> (ovr_q && $stable(lvl_q))); // R5
  AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ready_q == (lvl_q != '0)); // R4
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TICKS_PER_BIT = 16,
  localparam int MAX_LIM      = TICKS_PER_BIT * (4 * 8 + 12),
  localparam int LW           = $clog2(MAX_LIM + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic       active,
  input  logic [1:0] wlen,
  output logic       tmo
);
  logic [LW-1:0] cnt_q, limit;
  logic          tmo_q;

  // quiet period: four characters plus twelve bit times, in 16x ticks
  always_comb begin
    limit = LW'(TICKS_PER_BIT * (4 * (5 + int'(wlen)) + 12));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (restart || !active) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (tick && !tmo_q) begin
      if (cnt_q >= limit - 1'b1) tmo_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo = tmo_q;

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tmo_q); // R11
  AST_TMO_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    tmo_q |-> active); // R12
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          trig_en,
  input  logic [CW-1:0] trig_lvl,
  input  logic          ien,
  input  logic          tmo,
  output logic          irq
);
  logic hit, irq_q;

  assign hit = (level != '0) && (!trig_en || (level >= trig_lvl));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien && (hit || tmo);
  end

  assign irq = irq_q;

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_q); // R9
  AST_IRQ_TMO: assert property (@(posedge clk) disable iff (rst)
    (ien && tmo) |=> irq_q); // R10
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH         = 128,
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              tick16,
  input  logic              host_rd,
  input  logic [1:0]        wlen_sel,
  input  logic              rx_ien,
  input  logic              trig_en,
  input  logic [CNT_W-1:0]  trig_lvl,
  output logic [CHAR_W-1:0] rhr_data,
  output logic [4:0]        lsr_flags,
  output logic              rx_irq,
  output logic              rx_tmo
);
  rxq_entry_t       in_word, head;
  logic [CNT_W-1:0] level;
  logic             ready, overrun, push_ok, pop_ok, tmo;

  assign in_word = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(rx_valid), .wr_word(in_word), .rd_en(host_rd),
    .head(head), .level(level), .ready(ready), .overrun(overrun),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  rxq_timeout #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tmo (
    .clk(clk), .rst(rst), .tick(tick16), .restart(push_ok || pop_ok),
    .active(ready), .wlen(wlen_sel), .tmo(tmo)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .level(level), .trig_en(trig_en), .trig_lvl(trig_lvl),
    .ien(rx_ien), .tmo(tmo), .irq(rx_irq)
  );

  assign rhr_data  = head.data;
  assign lsr_flags = {head.brk & ready, head.frm & ready, head.par & ready, overrun, ready};
  assign rx_tmo    = tmo;

  AST_TMO_READY: assert property (@(posedge clk) disable iff (rst)
    rx_tmo |-> lsr_flags[0]); // R12
endmodule

// File: tb/rxq_top_test.sv
module rxq_top_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic       rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic [7:0] rx_data = 0;
  logic       tick16 = 1, host_rd = 0, rx_ien = 0, trig_en = 0;
  logic [1:0] wlen_sel = 2'b11;
  logic [7:0] trig_lvl = 8'd1;
  logic [7:0] rhr_data;
  logic [4:0] lsr_flags;
  logic       rx_irq, rx_tmo;
  int checks = 0, fails = 0;

  // entry format {brk, frm, par, data[7:0]}
  localparam logic [10:0] VEC [0:7] = '{11'h0A5, 11'h13C, 11'h2FF, 11'h400,
                                        11'h712, 11'h001, 11'h380, 11'h55A};

  rxq_top uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [10:0] w);
    {rx_brk, rx_frm_err, rx_par_err, rx_data} = w;
    rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pop();
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R4 reset lsr", lsr_flags, 0);
    chk("R4 reset irq", rx_irq, 0);
    chk("R4 reset tmo", rx_tmo, 0);

    // table walk: R1 order, R2 head timing, R3 tags
    for (int i = 0; i < 8; i++) push(VEC[i]);
    for (int i = 0; i < 8; i++) begin
      chk("R1 R2 head data", rhr_data, VEC[i][7:0]);
      chk("R3 head tags", lsr_flags[4:2], VEC[i][10:8]);
      chk("R4 ready", lsr_flags[0], 1);
      pop();
    end
    chk("R3 R4 empty lsr", lsr_flags, 0);

    // R6 read while empty
    pop();
    chk("R6 still empty", lsr_flags[0], 0);
    push(11'h05A);
    chk("R2 bypass head", rhr_data, 8'h5A);
    pop();
    chk("R6 one entry only", lsr_flags[0], 0);

    // R1 capacity and R5 overrun
    for (int i = 0; i < 128; i++) push({3'b000, 8'(i)});
    chk("R5 no overrun at full", lsr_flags[1], 0);
    push(11'h7EE);
    chk("R5 overrun set", lsr_flags[1], 1);
    for (int i = 0; i < 128; i++) begin
      chk("R1 R5 fill order", rhr_data, i);
      pop();
      if (i == 0) chk("R5 overrun cleared by read", lsr_flags[1], 0);
    end
    chk("R5 dropped char absent", lsr_flags[0], 0);

    // R7 per-character interrupt, R9 mask
    rx_ien = 1; trig_en = 0;
    push(11'h011);
    chk("R7 irq latency", rx_irq, 0);
    @(negedge clk);
    chk("R7 irq per char", rx_irq, 1);
    rx_ien = 0;
    @(negedge clk);
    chk("R9 irq masked", rx_irq, 0);
    rx_ien = 1;
    pop();
    @(negedge clk);
    chk("R7 irq drops when empty", rx_irq, 0);

    // R8 trigger level
    trig_en = 1; trig_lvl = 8'd4;
    for (int i = 0; i < 3; i++) push(11'h020);
    @(negedge clk);
    chk("R8 below trigger", rx_irq, 0);
    push(11'h021);
    @(negedge clk);
    chk("R8 at trigger", rx_irq, 1);
    pop();
    @(negedge clk);
    chk("R8 back below", rx_irq, 0);
    for (int i = 0; i < 3; i++) pop();

    // R10 timeout, 5-bit words: L = 512
    wlen_sel = 2'b00;
    push(11'h030);
    idle(511);
    chk("R10 tmo not yet", rx_tmo, 0);
    chk("R10 irq not yet", rx_irq, 0);
    @(negedge clk);
    chk("R10 tmo at 512", rx_tmo, 1);
    @(negedge clk);
    chk("R10 irq from tmo", rx_irq, 1);
    pop();
    chk("R11 R12 tmo cleared", rx_tmo, 0);

    // R11 restart by write and by read
    push(11'h031);
    idle(300);
    push(11'h032);
    idle(300);
    chk("R11 write restarts", rx_tmo, 0);
    idle(211);
    chk("R11 tmo not yet", rx_tmo, 0);
    @(negedge clk);
    chk("R11 tmo after restart", rx_tmo, 1);
    pop();
    chk("R11 read clears", rx_tmo, 0);
    idle(511);
    chk("R11 read restarts", rx_tmo, 0);
    pop();
    idle(800);
    chk("R12 no tmo when empty", rx_tmo, 0);

    // R10 timeout, 8-bit words: L = 704
    wlen_sel = 2'b11;
    push(11'h040);
    idle(703);
    chk("R10 8-bit not yet", rx_tmo, 0);
    @(negedge clk);
    chk("R10 8-bit at 704", rx_tmo, 1);
    pop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule